// File: doc/BRIEF.md
# Compensated Real-Time Clock Seconds Counter

This block is the timekeeping core of a real-time clock. A 16-bit prescaler advances on each cycle where the 32.768 kHz tick enable is high. Each time it completes a period, a 32-bit seconds counter steps by one. The length of that period can be trimmed by a signed 8-bit correction. The correction is applied to one second out of every (interval + 1) seconds, which gives fine average trimming of a crystal that runs fast or slow.

Around the counter the block keeps an alarm comparator and three sticky flags: time invalid, time overflow and alarm. It also provides a selectable sub-second tap from 1 Hz to 128 Hz and a single interrupt output, which is the OR of the enabled sources. Software reaches the block through simple write ports, one per register group, and reads the counter values, flags and compensation state directly from the outputs.

Top module: `rtc_core`

## Requirements
- R1: After reset the seconds output reads 0, the prescaler is 0, the invalid flag is 1, the overflow and alarm flags are 0, and `irq` is 0.
- R2: While counting is enabled, the prescaler advances by one on each cycle with `tick_en` high. With no correction, the seconds counter increments on the edge where the prescaler completes 32768 advances, and the prescaler restarts from 0.
- R3: The prescaler period is 32768 minus the active correction, read as 8-bit two's complement: 0x01 gives 32767, 0x7F gives 32641, 0xFF gives 32769 and 0x80 gives 32896.
- R4: The correction is active in one second out of every (interval + 1). `comp_now` shows the correction while `interval_cnt` is 0 and shows 0 otherwise. `interval_cnt` reloads from the interval at each second boundary where it is 0, and counts down by one at every other boundary. A write of the compensation port sets `interval_cnt` to 0.
- R5: While counting is disabled, neither the prescaler nor the seconds counter changes, whatever `tick_en` does.
- R6: Writes to the seconds and prescaler ports are ignored while counting is enabled.
- R7: In low-power mode (`ctrl_lowpow` = 1) the prescaler advances by 32 per tick. When it wraps, the part beyond the period is kept as the new prescaler value.
- R8: The overflow flag sets when the seconds counter increments from all ones. While the invalid flag or the overflow flag is set, the seconds output reads 0. A seconds write accepted while counting is disabled clears both flags.
- R9: The alarm flag sets when the seconds counter increments to a value equal to the alarm register. A write to the alarm port clears the flag.
- R10: `tap_out` equals prescaler bit (14 − `ctrl_tap_sel`). Select value n gives a rate of 2^n Hz.
- R11: `irq` is the OR of the flags masked by the interrupt enables. Enable bit 0 is invalid, bit 1 is overflow, bit 2 is alarm and bit 3 is the tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 32.768 kHz tick qualifier |
| sec_we | input | 1 | Seconds write strobe |
| sec_wdata | input | 32 | Seconds write value |
| presc_we | input | 1 | Prescaler write strobe |
| presc_wdata | input | 16 | Prescaler write value |
| alarm_we | input | 1 | Alarm write strobe (also clears the alarm flag) |
| alarm_wdata | input | 32 | Alarm compare value |
| comp_we | input | 1 | Compensation write strobe |
| comp_wdata | input | 8 | Signed correction value |
| intv_wdata | input | 8 | Compensation interval |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_count_en | input | 1 | Counting enable |
| ctrl_lowpow | input | 1 | Low-power step of 32 |
| ctrl_tap_sel | input | 3 | Tap rate select, 2^n Hz |
| irq_en_we | input | 1 | Interrupt enable write strobe |
| irq_en_wdata | input | 4 | Enables: 0 invalid, 1 overflow, 2 alarm, 3 tap |
| seconds | output | 32 | Seconds readback, forced to 0 while invalid or overflowed |
| prescaler | output | 16 | Prescaler value |
| flag_invalid | output | 1 | Time invalid flag |
| flag_overflow | output | 1 | Seconds overflow flag |
| flag_alarm | output | 1 | Alarm flag |
| comp_now | output | 8 | Correction active for the current second |
| interval_cnt | output | 8 | Interval down-counter |
| tap_out | output | 1 | Sub-second tap |
| irq | output | 1 | Masked interrupt |

## Verification
A corrupted prescaler limit or correction shows up as a seconds step on the wrong cycle. The bench preloads the prescaler a few counts below the expected limit, so it sees the error within tens of cycles rather than a full second. A wrong interval counter shows up as `comp_now` and `interval_cnt` disagreeing with the expected rotation at the very next second boundary. Flag errors appear at once on `seconds`, which is forced to zero, and on `irq`.

// File: rtl/rtc_pkg.sv
// Shared constants for the compensated RTC core.
// Assumes the interrupt-enable word is ordered as listed below.
package rtc_pkg;
    localparam int IE_W   = 4;
    localparam int IE_INV = 0;
    localparam int IE_OVF = 1;
    localparam int IE_ALM = 2;
    localparam int IE_TAP = 3;

    typedef struct packed {
        logic alarm;
        logic overflow;
        logic invalid;
    } rtc_flags_t;
endpackage

// File: rtl/rtc_prescaler.sv
// Prescaler with signed period correction and interval rotation.
// Produces a one-cycle sec_tick on the edge where the prescaler completes
// its period. Assumes BASE + 2^(CW-1) fits in PW bits.
module rtc_prescaler #(
    parameter int PW       = 16,
    parameter int CW       = 8,
    parameter int BASE     = 32768,
    parameter int LP_SHIFT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          cnt_en,
    input  logic          low_pow,
    input  logic          presc_we,
    input  logic [PW-1:0] presc_wdata,
    input  logic          comp_we,
    input  logic [CW-1:0] comp_wdata,
    input  logic [CW-1:0] intv_wdata,
    output logic [PW-1:0] presc_q,
    output logic          sec_tick,
    output logic [CW-1:0] comp_now,
    output logic [CW-1:0] intv_cnt
);
    localparam int LW = PW + 2;

    logic [CW-1:0] comp_q, intv_q;
    logic [LW-1:0] limit, step, nxt;
    logic          advance;

    // Period limit, step size and wrap detection.
    always_comb begin
        comp_now = (intv_cnt == '0) ? comp_q : '0;
        limit    = LW'(BASE) - {{(LW-CW){comp_now[CW-1]}}, comp_now};
        step     = low_pow ? LW'(1 << LP_SHIFT) : LW'(1);
        nxt      = {2'b00, presc_q} + step;
        advance  = tick_en && cnt_en;
        sec_tick = advance && (nxt >= limit);
    end

    // Prescaler register: software load while stopped, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                  presc_q <= '0;
        else if (presc_we && !cnt_en) presc_q <= presc_wdata;
        else if (sec_tick)           presc_q <= PW'(nxt - limit);
        else if (advance)            presc_q <= PW'(nxt);
    end

    // Correction value, interval and rotating interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp_q   <= '0;
            intv_q   <= '0;
            intv_cnt <= '0;
        end else if (comp_we) begin
            comp_q   <= comp_wdata;
            intv_q   <= intv_wdata;
            intv_cnt <= '0;
        end else if (sec_tick) begin
            intv_cnt <= (intv_cnt == '0) ? intv_q : intv_cnt - 1'b1;
        end
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !presc_we) |=> $stable(presc_q));
    p_wr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && presc_we && !tick_en) |=> $stable(presc_q));
    p_intv_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(comp_we) |-> (intv_cnt == '0));
endmodule

// File: rtl/rtc_seconds.sv
// Seconds counter with alarm compare and sticky invalid/overflow/alarm flags.
// Assumes sec_tick only occurs while counting is enabled.
module rtc_seconds #(
    parameter int SW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en,
    input  logic               sec_tick,
    input  logic               sec_we,
    input  logic [SW-1:0]      sec_wdata,
    input  logic               alarm_we,
    input  logic [SW-1:0]      alarm_wdata,
    output logic [SW-1:0]      sec_rd,
    output rtc_pkg::rtc_flags_t flags
);
    logic [SW-1:0] sec_q, alarm_q, sec_inc;
    logic          wr_ok;

    // Increment value, write qualification and masked readback.
    always_comb begin
        sec_inc = sec_q + 1'b1;
        wr_ok   = sec_we && !cnt_en;
        sec_rd  = (flags.invalid || flags.overflow) ? '0 : sec_q;
    end

    // Seconds register plus the invalid and overflow flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q          <= '0;
            flags.invalid  <= 1'b1;
            flags.overflow <= 1'b0;
        end else if (wr_ok) begin
            sec_q          <= sec_wdata;
            flags.invalid  <= 1'b0;
            flags.overflow <= 1'b0;
        end else if (sec_tick) begin
            sec_q <= sec_inc;
            if (&sec_q) flags.overflow <= 1'b1;
        end
    end

    // Alarm register and alarm flag; a write clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q     <= '0;
            flags.alarm <= 1'b0;
        end else if (alarm_we) begin
            alarm_q     <= alarm_wdata;
            flags.alarm <= 1'b0;
        end else if (sec_tick && (sec_inc == alarm_q)) begin
            flags.alarm <= 1'b1;
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (sec_q == $past(sec_q) + 1'b1));
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && (&sec_q)) |=> flags.overflow);
    p_alarm_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_we |=> !flags.alarm);
endmodule

// File: rtl/rtc_irq.sv
// Sub-second tap selection and masked interrupt combine.
// Assumes the top prescaler bit below the period MSB is 1 Hz (bit PW-2).
module rtc_irq #(
    parameter int PW   = 16,
    parameter int SELW = 3
) (
    input  logic [PW-1:0]             presc_q,
    input  logic [SELW-1:0]           tap_sel,
    input  rtc_pkg::rtc_flags_t       flags,
    input  logic [rtc_pkg::IE_W-1:0]  irq_en,
    output logic                      tap_out,
    output logic                      irq
);
    localparam int IW  = $clog2(PW);
    localparam int TOP = PW - 2;

    logic [IW-1:0]              idx;
    logic [rtc_pkg::IE_W-1:0]   src;

    // Tap bit pick and OR of enabled sources.
    always_comb begin
        idx                  = IW'(TOP) - IW'(tap_sel);
        tap_out              = presc_q[idx];
        src                  = '0;
        src[rtc_pkg::IE_INV] = flags.invalid;
        src[rtc_pkg::IE_OVF] = flags.overflow;
        src[rtc_pkg::IE_ALM] = flags.alarm;
        src[rtc_pkg::IE_TAP] = tap_out;
        irq                  = |(src & irq_en);
    end
endmodule

// File: rtl/rtc_core.sv
// Compensated RTC core top: control and interrupt-enable registers, plus the
// prescaler, seconds and interrupt stages. Bus decode is outside the block.
module rtc_core #(
    parameter int PW   = 16,
    parameter int SW   = 32,
    parameter int CW   = 8,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            sec_we,
    input  logic [SW-1:0]   sec_wdata,
    input  logic            presc_we,
    input  logic [PW-1:0]   presc_wdata,
    input  logic            alarm_we,
    input  logic [SW-1:0]   alarm_wdata,
    input  logic            comp_we,
    input  logic [CW-1:0]   comp_wdata,
    input  logic [CW-1:0]   intv_wdata,
    input  logic            ctrl_we,
    input  logic            ctrl_count_en,
    input  logic            ctrl_lowpow,
    input  logic [SELW-1:0] ctrl_tap_sel,
    input  logic            irq_en_we,
    input  logic [3:0]      irq_en_wdata,
    output logic [SW-1:0]   seconds,
    output logic [PW-1:0]   prescaler,
    output logic            flag_invalid,
    output logic            flag_overflow,
    output logic            flag_alarm,
    output logic [CW-1:0]   comp_now,
    output logic [CW-1:0]   interval_cnt,
    output logic            tap_out,
    output logic            irq
);
    import rtc_pkg::*;

    logic            cnt_en_q, lowpow_q, sec_tick;
    logic [SELW-1:0] tap_sel_q;
    logic [IE_W-1:0] irq_en_q;
    rtc_flags_t      flags;

    // Control register: enable, step mode and tap select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en_q  <= 1'b0;
            lowpow_q  <= 1'b0;
            tap_sel_q <= '0;
        end else if (ctrl_we) begin
            cnt_en_q  <= ctrl_count_en;
            lowpow_q  <= ctrl_lowpow;
            tap_sel_q <= ctrl_tap_sel;
        end
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_en_q <= '0;
        else if (irq_en_we) irq_en_q <= irq_en_wdata;
    end

    rtc_prescaler #(.PW(PW), .CW(CW)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_en(cnt_en_q),
        .low_pow(lowpow_q), .presc_we(presc_we), .presc_wdata(presc_wdata),
        .comp_we(comp_we), .comp_wdata(comp_wdata), .intv_wdata(intv_wdata),
        .presc_q(prescaler), .sec_tick(sec_tick), .comp_now(comp_now),
        .intv_cnt(interval_cnt)
    );

    rtc_seconds #(.SW(SW)) u_sec (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en_q), .sec_tick(sec_tick),
        .sec_we(sec_we), .sec_wdata(sec_wdata), .alarm_we(alarm_we),
        .alarm_wdata(alarm_wdata), .sec_rd(seconds), .flags(flags)
    );

    rtc_irq #(.PW(PW), .SELW(SELW)) u_irq (
        .presc_q(prescaler), .tap_sel(tap_sel_q), .flags(flags),
        .irq_en(irq_en_q), .tap_out(tap_out), .irq(irq)
    );

    assign flag_invalid  = flags.invalid;
    assign flag_overflow = flags.overflow;
    assign flag_alarm    = flags.alarm;

    p_irq_alarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_alarm && irq_en_q[IE_ALM]) |-> irq);
    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_q == '0) |-> !irq);
    p_no_tick_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_q |-> !sec_tick);
endmodule

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
    logic sec_we = 0, presc_we = 0, alarm_we = 0, comp_we = 0, ctrl_we = 0, irq_en_we = 0;
    logic [31:0] sec_wdata = 0, alarm_wdata = 0;
    logic [15:0] presc_wdata = 0;
    logic [7:0]  comp_wdata = 0, intv_wdata = 0;
    logic        ctrl_count_en = 0, ctrl_lowpow = 0;
    logic [2:0]  ctrl_tap_sel = 0;
    logic [3:0]  irq_en_wdata = 0;
    logic [31:0] seconds;
    logic [15:0] prescaler;
    logic        flag_invalid, flag_overflow, flag_alarm, tap_out, irq;
    logic [7:0]  comp_now, interval_cnt;
    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    rtc_core dut (.*);

    function automatic int exp_limit(input logic [7:0] c);
        return 32768 - int'($signed(c));
    endfunction

    function automatic logic exp_tap(input logic [15:0] p, input logic [2:0] s);
        return p[14 - s];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask
    task automatic tick(input int n);
        tick_en = 1; repeat (n) @(negedge clk); tick_en = 0;
    endtask
    task automatic wr_ctrl(input logic en, input logic lp, input logic [2:0] s);
        ctrl_we = 1; ctrl_count_en = en; ctrl_lowpow = lp; ctrl_tap_sel = s; cyc(); ctrl_we = 0;
    endtask
    task automatic wr_sec(input logic [31:0] v);  sec_we = 1; sec_wdata = v; cyc(); sec_we = 0; endtask
    task automatic wr_presc(input logic [15:0] v); presc_we = 1; presc_wdata = v; cyc(); presc_we = 0; endtask
    task automatic wr_alarm(input logic [31:0] v); alarm_we = 1; alarm_wdata = v; cyc(); alarm_we = 0; endtask
    task automatic wr_comp(input logic [7:0] c, input logic [7:0] i);
        comp_we = 1; comp_wdata = c; intv_wdata = i; cyc(); comp_we = 0;
    endtask
    task automatic wr_ie(input logic [3:0] v); irq_en_we = 1; irq_en_wdata = v; cyc(); irq_en_we = 0; endtask

    // Preload the prescaler n counts short of wrap and check the step lands on tick n.
    task automatic measure(input string req, input logic [7:0] c, input int n);
        logic [31:0] s0;
        wr_ctrl(0, 0, 0);
        wr_presc(16'(exp_limit(c) - n));
        s0 = seconds;
        wr_ctrl(1, 0, 0);
        if (n > 1) begin tick(n - 1); check(req, seconds, s0); end
        tick(1);
        check(req, seconds, s0 + 1);
        check(req, {16'h0, prescaler}, 32'h0);
        wr_ctrl(0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] c;
        int n;
        void'($urandom(32'd20240611));
        repeat (3) cyc();
        rst_n = 1; cyc();
        // R1 reset state
        check("R1", seconds, 0);
        check("R1", {16'h0, prescaler}, 0);
        check("R1", {29'h0, flag_invalid, flag_overflow, flag_alarm}, 32'h4);
        check("R1", {31'h0, irq}, 0);
        // R11 invalid source masked then enabled
        wr_ie(4'b0001); check("R11", {31'h0, irq}, 1);
        wr_ie(4'b0000); check("R11", {31'h0, irq}, 0);
        // R8 seconds write clears invalid
        wr_sec(32'd100);
        check("R8", {31'h0, flag_invalid}, 0);
        check("R8", seconds, 100);
        // R5 disabled: no advance
        wr_presc(16'd40); tick(5);
        check("R5", {16'h0, prescaler}, 40);
        check("R5", seconds, 100);
        // R2 advance by one per tick, full uncorrected second
        wr_comp(8'h00, 8'h00);
        wr_presc(16'd0); wr_ctrl(1, 0, 0);
        tick(7); check("R2", {16'h0, prescaler}, 7);
        tick(32768 - 8); check("R2", seconds, 100);
        tick(1); check("R2", seconds, 101);
        check("R2", {16'h0, prescaler}, 0);
        // R6 writes ignored while enabled
        wr_presc(16'd1234); check("R6", {16'h0, prescaler}, 0);
        wr_sec(32'd55);     check("R6", seconds, 101);
        wr_ctrl(0, 0, 0);
        // R3 directed correction values
        wr_comp(8'h01, 0); measure("R3", 8'h01, 6);
        wr_comp(8'h7F, 0); measure("R3", 8'h7F, 4);
        wr_comp(8'hFF, 0); measure("R3", 8'hFF, 9);
        wr_comp(8'h80, 0); measure("R3", 8'h80, 3);
        // R3 random corrections
        for (int k = 0; k < 8; k++) begin
            c = 8'($urandom % 256);
            n = 1 + int'($urandom % 16);
            wr_comp(c, 0);
            measure("R3", c, n);
        end
        // R4 interval rotation: correction 5, interval 2
        wr_comp(8'd5, 8'd2);
        check("R4", {24'h0, comp_now}, 5);
        check("R4", {24'h0, interval_cnt}, 0);
        measure("R4", 8'd5, 3);
        check("R4", {24'h0, interval_cnt}, 2);
        check("R4", {24'h0, comp_now}, 0);
        measure("R4", 8'd0, 2);
        check("R4", {24'h0, interval_cnt}, 1);
        measure("R4", 8'd0, 2);
        check("R4", {24'h0, interval_cnt}, 0);
        check("R4", {24'h0, comp_now}, 5);
        wr_comp(8'd0, 8'd0);
        // R7 low-power step of 32
        wr_presc(16'd0); wr_ctrl(1, 1, 0);
        tick(3); check("R7", {16'h0, prescaler}, 96);
        wr_ctrl(0, 1, 0); wr_sec(32'd20); wr_presc(16'd32746); wr_ctrl(1, 1, 0);
        tick(1);
        check("R7", seconds, 21);
        check("R7", {16'h0, prescaler}, 10);
        wr_ctrl(0, 0, 0);
        // R10 tap selection, random prescaler values
        for (int k = 0; k < 8; k++) begin
            logic [15:0] p;
            logic [2:0]  s;
            p = 16'($urandom);
            s = 3'(k);
            wr_presc(p); wr_ctrl(0, 0, s);
            check("R10", {31'h0, tap_out}, {31'h0, exp_tap(p, s)});
        end
        wr_ie(4'b1000);
        check("R11", {31'h0, irq}, {31'h0, tap_out});
        wr_ie(4'b0000);
        // R8 overflow from all ones
        wr_ctrl(0, 0, 0); wr_sec(32'hFFFF_FFFF); wr_presc(16'd32767); wr_ctrl(1, 0, 0);
        tick(1);
        check("R8", {31'h0, flag_overflow}, 1);
        check("R8", seconds, 0);
        wr_ie(4'b0010); check("R11", {31'h0, irq}, 1);
        wr_ie(4'b0000);
        wr_ctrl(0, 0, 0); wr_sec(32'd5);
        check("R8", {31'h0, flag_overflow}, 0);
        check("R8", seconds, 5);
        // R9 alarm match and clear
        wr_sec(32'd6); wr_alarm(32'd7); wr_presc(16'd32767); wr_ctrl(1, 0, 0);
        check("R9", {31'h0, flag_alarm}, 0);
        tick(1);
        check("R9", seconds, 7);
        check("R9", {31'h0, flag_alarm}, 1);
        wr_ie(4'b0100); check("R11", {31'h0, irq}, 1);
        wr_alarm(32'd9);
        check("R9", {31'h0, flag_alarm}, 0);
        check("R11", {31'h0, irq}, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule